// File: doc/BRIEF.md
# Serial Configuration Word Loader

This block lets an external controller write several control words into a chip through three wires: a data line, a shift clock and a load strobe. The controller sends a 24-bit word with the most significant bit first. A rising edge on the shift clock moves one bit into a shift register. When the load strobe rises, the upper 22 bits of the word are copied into one of four parallel holding latches. The two bits sent last, the two least significant bits of the word, choose which latch. Each latch drives its 22 bits out in parallel to the rest of the chip. When a latch is written, its one-cycle update flag pulses.

All four serial pins and the enable pin are sampled in the block's own system clock domain. Each pin goes through a synchroniser of `SYNC_N` stages and then an edge detector. The controller must hold every pin level for at least `SYNC_N + 2` system clocks. When the chip-enable input is low, the block is powered down: the shift register and all latches are cleared, and load strobes are ignored.

Top module: `cfg_loader`

## Requirements
- R1: After `rst_n` is released, every bit of `cfg_word_o` and `cfg_upd_o` is 0.
- R2: Each rising edge of `ser_clk` shifts `ser_dat` into the bottom of a 24-bit shift register, so the bit sent first ends up as bit 23 of the word.
- R3: When more than 24 bits arrive before a load, only the last 24 bits sent are kept.
- R4: A rising edge of `ld_en` copies word bits 23..2 into latch k, where k is the value of word bits 1..0. Latch k drives `cfg_word_o[k*22 +: 22]`, and word bit 2 appears on the lowest bit of that slice. The other latches keep their values.
- R5: Each rising edge of `ld_en` makes exactly one transfer, however long `ld_en` then stays high.
- R6: `ser_clk` edges are ignored while `ld_en` is high, so the shift register keeps its contents.
- R7: While `chip_en` is low, the shift register and all four latches are held at zero.
- R8: While `chip_en` is low, rising edges of `ld_en` write no latch and raise no update flag.
- R9: Each write of latch k raises `cfg_upd_o[k]` for exactly one system clock, in the same cycle that the new value appears. At most one update flag is high at a time.
- R10: If `ser_clk` and `ld_en` rise in the same cycle, the bit on `ser_dat` is not shifted in, and the word held before that edge is the one loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_dat | input | 1 | Serial data, sent most significant bit first |
| ld_en | input | 1 | Load strobe; its rising edge starts a transfer |
| chip_en | input | 1 | Enable; low powers the block down |
| cfg_word_o | output | 88 | Four 22-bit latch contents; latch k is at bits k*22 and up |
| cfg_upd_o | output | 4 | One-cycle update flag for each latch |

## Verification
Two pairs of events can land in the same cycle. A shift edge can meet a load edge, and a load edge can arrive while the block is powered down. The first pair is provoked by raising `ser_clk` and `ld_en` at the same instant. The result is judged correct if the latch receives the previous word and a later reload with no new bits returns that same word. The second pair is provoked by pulsing the load strobe with `chip_en` low. The result is judged correct if all latches read zero, the update-pulse counts do not change, and a first load after re-enable writes zero into latch 0.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int unsigned DEF_WORD_W = 24;
  localparam int unsigned DEF_CTRL_W = 2;
  localparam int unsigned DEF_SYNC_N = 2;

  typedef struct packed {
    logic chip_en;
    logic ld_en;
    logic ser_dat;
    logic ser_clk;
  } pins_t;

  localparam int unsigned PINS_W = $bits(pins_t);
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned N_BITS = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_BITS-1:0] async_i,
  output logic [N_BITS-1:0] lvl_o,
  output logic [N_BITS-1:0] rise_o
);
  for (genvar b = 0; b < N_BITS; b++) begin : g_bit
    logic [STAGES:0] chain_q;
    logic [STAGES:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-1:0], async_i[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end

    assign lvl_o[b]  = chain_q[STAGES-1];
    assign rise_o[b] = chain_q[STAGES-1] & ~chain_q[STAGES];
  end
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              shift_en,
  input  logic              hold,
  input  logic              din,
  output logic [WORD_W-1:0] sr_o
);
  logic [WORD_W-1:0] sr_q;
  logic [WORD_W-1:0] sr_d;

  always_comb begin
    if (!ce)                  sr_d = '0;
    else if (shift_en && !hold) sr_d = {sr_q[WORD_W-2:0], din};
    else                      sr_d = sr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign sr_o = sr_q;
endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank #(
  parameter int unsigned WORD_W = 24,
  parameter int unsigned CTRL_W = 2,
  localparam int unsigned PAY_W = WORD_W - CTRL_W,
  localparam int unsigned N_LAT = 1 << CTRL_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ce,
  input  logic                   load,
  input  logic [WORD_W-1:0]      word_i,
  output logic [N_LAT*PAY_W-1:0] lat_o,
  output logic [N_LAT-1:0]       upd_o
);
  logic [CTRL_W-1:0] sel;
  logic [PAY_W-1:0]  payload;

  assign sel     = word_i[CTRL_W-1:0];
  assign payload = word_i[WORD_W-1:CTRL_W];

  for (genvar i = 0; i < N_LAT; i++) begin : g_lat
    logic             hit;
    logic [PAY_W-1:0] lat_q;
    logic [PAY_W-1:0] lat_d;
    logic             upd_q;

    assign hit = ce && load && (sel == CTRL_W'(i));

    always_comb begin
      if (!ce)      lat_d = '0;
      else if (hit) lat_d = payload;
      else          lat_d = lat_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lat_q <= '0;
        upd_q <= 1'b0;
      end else begin
        lat_q <= lat_d;
        upd_q <= hit;
      end
    end

    assign lat_o[i*PAY_W +: PAY_W] = lat_q;
    assign upd_o[i]                = upd_q;
  end
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned CTRL_W = DEF_CTRL_W,
  parameter int unsigned SYNC_N = DEF_SYNC_N,
  localparam int unsigned PAY_W = WORD_W - CTRL_W,
  localparam int unsigned N_LAT = 1 << CTRL_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ser_clk,
  input  logic                   ser_dat,
  input  logic                   ld_en,
  input  logic                   chip_en,
  output logic [N_LAT*PAY_W-1:0] cfg_word_o,
  output logic [N_LAT-1:0]       cfg_upd_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_s = rst_q[1];

  pins_t pins_raw, pins_lvl, pins_rise;
  logic [PINS_W-1:0] lvl_vec, rise_vec;

  always_comb begin
    pins_raw.chip_en = chip_en;
    pins_raw.ld_en   = ld_en;
    pins_raw.ser_dat = ser_dat;
    pins_raw.ser_clk = ser_clk;
  end

  cfg_sync #(.N_BITS(PINS_W), .STAGES(SYNC_N)) u_sync (
    .clk    (clk),
    .rst_n  (rst_s),
    .async_i(pins_raw),
    .lvl_o  (lvl_vec),
    .rise_o (rise_vec)
  );

  assign pins_lvl  = pins_t'(lvl_vec);
  assign pins_rise = pins_t'(rise_vec);

  logic              ce_s, le_s, le_rise;
  logic [WORD_W-1:0] sr;

  assign ce_s    = pins_lvl.chip_en;
  assign le_s    = pins_lvl.ld_en;
  assign le_rise = pins_rise.ld_en;

  cfg_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_s),
    .ce      (ce_s),
    .shift_en(pins_rise.ser_clk),
    .hold    (le_s),
    .din     (pins_lvl.ser_dat),
    .sr_o    (sr)
  );

  cfg_latch_bank #(.WORD_W(WORD_W), .CTRL_W(CTRL_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_s),
    .ce    (ce_s),
    .load  (le_rise),
    .word_i(sr),
    .lat_o (cfg_word_o),
    .upd_o (cfg_upd_o)
  );
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
  parameter int unsigned WORD_W = 24,
  parameter int unsigned CTRL_W = 2,
  localparam int unsigned PAY_W = WORD_W - CTRL_W,
  localparam int unsigned N_LAT = 1 << CTRL_W
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ce,
  input logic                   le_s,
  input logic                   le_rise,
  input logic [WORD_W-1:0]      sr,
  input logic [N_LAT*PAY_W-1:0] lat,
  input logic [N_LAT-1:0]       upd
);
  p_upd_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd));

  p_clear_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> (lat == '0 && sr == '0));

  p_no_upd_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> upd == '0);

  p_shift_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && le_s) |=> $stable(sr));

  p_lat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !le_rise) |=> $stable(lat));

  p_upd_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && le_rise) |=> upd[$past(sr[CTRL_W-1:0])]);
endmodule

bind cfg_loader cfg_loader_chk #(.WORD_W(WORD_W), .CTRL_W(CTRL_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_s),
  .ce     (ce_s),
  .le_s   (le_s),
  .le_rise(le_rise),
  .sr     (sr),
  .lat    (cfg_word_o),
  .upd    (cfg_upd_o)
);

// File: tb/tb_cfg_loader.sv
module tb_cfg_loader;
  localparam int W = 24;
  localparam int P = 22;
  localparam int N = 4;
  localparam int HOLD = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ld_en = 1'b0, chip_en = 1'b1;
  logic [N*P-1:0] cfg_word_o;
  logic [N-1:0]   cfg_upd_o;

  always #2 clk = ~clk;

  cfg_loader dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ld_en(ld_en), .chip_en(chip_en), .cfg_word_o(cfg_word_o), .cfg_upd_o(cfg_upd_o)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [W-1:0] exp_sr = '0;
  logic [P-1:0] exp_lat [N];
  int exp_cnt [N];
  int upd_cnt [N];
  int upd_multi = 0;

  initial for (int i = 0; i < N; i++) begin exp_lat[i] = '0; exp_cnt[i] = 0; upd_cnt[i] = 0; end

  always @(negedge clk) begin
    if ($countones(cfg_upd_o) > 1) upd_multi++;
    for (int i = 0; i < N; i++) if (cfg_upd_o[i]) upd_cnt[i]++;
  end

  function automatic logic [W-1:0] shifted(logic [W-1:0] s, logic b);
    return {s[W-2:0], b};
  endfunction

  task automatic chk(string req, logic [P-1:0] act, logic [P-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    for (int i = 0; i < N; i++) begin
      chk(req, cfg_word_o[i*P +: P], exp_lat[i]);
      chk({req, " upd count"}, P'(upd_cnt[i]), P'(exp_cnt[i]));
    end
    chk({req, " R9 single flag"}, P'(upd_multi), '0);
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    @(negedge clk); ser_dat = b;
    wait_n(HOLD);
    ser_clk = 1'b1;
    if (chip_en && !ld_en) exp_sr = shifted(exp_sr, b);
    wait_n(HOLD);
    ser_clk = 1'b0;
    wait_n(HOLD);
  endtask

  task automatic send_word(logic [31:0] w, int len);
    for (int i = len - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic do_load(int hold_cycles);
    @(negedge clk); ld_en = 1'b1;
    if (chip_en) begin
      exp_lat[exp_sr[1:0]] = exp_sr[W-1:2];
      exp_cnt[exp_sr[1:0]]++;
    end
    wait_n(hold_cycles);
    ld_en = 1'b0;
    wait_n(HOLD);
  endtask

  initial begin
    logic [P-1:0] snap;
    void'($urandom(32'd20240611));
    wait_n(3);
    rst_n = 1'b1;
    wait_n(6);
    // R1 reset state
    chk_all("R1 reset");

    // R2 R4 directed: one word per latch code
    for (int k = 0; k < N; k++) begin
      send_word({8'h0, 22'h2AAAA5 ^ P'(k * 22'h01F3), 2'(k)}, W);
      do_load(HOLD);
      chk_all("R2 R4 directed");
    end

    // R3 R4 random words, some longer than 24 bits
    for (int n = 0; n < 24; n++) begin
      int len = W + int'($urandom_range(0, 8));
      send_word($urandom(), len);
      do_load(HOLD);
      chk_all(len > W ? "R3 overlength" : "R4 random");
    end

    // R5 long held strobe still one transfer
    send_word({8'h0, 22'h13579B, 2'd2}, W);
    do_load(50);
    chk_all("R5 long strobe");

    // R6 shifting while strobe high ignored; reload gives same word
    snap = exp_sr[W-1:2];
    @(negedge clk); ld_en = 1'b1;
    exp_lat[exp_sr[1:0]] = exp_sr[W-1:2]; exp_cnt[exp_sr[1:0]]++;
    wait_n(HOLD);
    for (int i = 0; i < 5; i++) send_bit(i[0]);
    ld_en = 1'b0; wait_n(HOLD);
    do_load(HOLD);
    chk_all("R6 shift under strobe");
    chk("R6 word kept", exp_sr[W-1:2], snap);

    // R10 shift edge and load edge together
    send_word({8'h0, 22'h0F0F0F, 2'd1}, W);
    @(negedge clk); ser_dat = 1'b1; wait_n(HOLD);
    ser_clk = 1'b1; ld_en = 1'b1;
    exp_lat[1] = 22'h0F0F0F; exp_cnt[1]++;
    wait_n(HOLD);
    ser_clk = 1'b0; ld_en = 1'b0; wait_n(HOLD);
    chk_all("R10 coincident edges");
    do_load(HOLD);
    chk_all("R10 reload after coincidence");

    // R7 R8 power down
    @(negedge clk); chip_en = 1'b0;
    exp_sr = '0;
    for (int i = 0; i < N; i++) exp_lat[i] = '0;
    wait_n(HOLD);
    send_bit(1'b1);
    do_load(HOLD);
    chk_all("R7 R8 powered down");
    @(negedge clk); chip_en = 1'b1; wait_n(HOLD);
    do_load(HOLD);
    chk_all("R7 shift reg cleared");
    send_word({8'h0, 22'h3FFFFF, 2'd3}, W);
    do_load(HOLD);
    chk_all("R9 after re-enable");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule